// File: doc/BRIEF.md
# Protection Key Access Checker

This unit decides whether a memory access that has already been translated breaks the per-page protection-key rights. Each leaf page-table entry carries a 4-bit key that names one of sixteen rights domains. A 32-bit rights register holds two bits for each domain. One bit forbids every data access to pages tagged with that key. The other bit forbids data writes. The unit looks up the domain for the presented entry and gates the result with the paging and control state. It returns a registered violation flag together with a page-fault error-code word.

The surrounding page walker presents one request per valid strobe. A request carries the leaf entry, the access attributes and the current control bits. One clock later a matching valid strobe returns the outcome. Software loads the rights register through a write-enable port and can read it back at any time. Only the key part of the fault decision is made here. Present, supervisor and no-execute checks stay with the walker, which merges its own error bits with the ones reported here.

Top module: `pkey_access_checker`

## Requirements
- R1: While reset is asserted the rights register reads zero and resp_valid, resp_violation and resp_err are all zero, whatever the other inputs do.
- R2: A rights write with rights_we high is visible on rights_rdata after the next clock edge. A request presented in the same cycle as the write is judged with the old rights. A request presented in the next cycle is judged with the new rights.
- R3: The key is bits 62:59 of req_pte. For key k, rights bit 2k is the access-disable bit and bit 2k+1 is the write-disable bit. Bits of other keys have no effect.
- R4: No violation is raised unless ctl_key_en and ctl_long_mode are both 1.
- R5: No violation is raised when req_present is 0 or req_rsvd is 1.
- R6: No violation is raised for an instruction fetch (req_fetch = 1).
- R7: No violation is raised when the user bit, bit 2 of req_pte, is 0.
- R8: When every gate of R4 to R7 is open and the key's access-disable bit is 1, a violation is raised for both reads and writes.
- R9: When every gate is open and the key's write-disable bit is 1, a violation is raised for a write (req_write = 1) if ctl_wp is 1 or req_user is 1. It is not raised for a read, nor for a supervisor write with ctl_wp = 0.
- R10: With an all-zero rights register no violation is raised for any input.
- R11: resp_err carries bit 0 present, bit 1 write, bit 2 user, bit 3 reserved-bit, bit 4 fetch and bit 5 protection-key. All other bits are zero. Bit 5 equals resp_violation.
- R12: resp_valid is high exactly one clock after a cycle with req_valid high. In a cycle with resp_valid low, resp_violation and resp_err are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_pte | input | 64 | Leaf page-table entry of the access |
| req_write | input | 1 | Access is a data write |
| req_user | input | 1 | Access comes from user mode |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_rsvd | input | 1 | Walker found a reserved-bit violation |
| req_present | input | 1 | Page is present |
| ctl_key_en | input | 1 | Protection keys enabled |
| ctl_long_mode | input | 1 | Long mode active |
| ctl_wp | input | 1 | Supervisor write-protect enabled |
| rights_we | input | 1 | Load strobe for the rights register |
| rights_wdata | input | 32 | New rights value |
| rights_rdata | output | 32 | Current rights value |
| resp_valid | output | 1 | Result strobe, one clock after req_valid |
| resp_violation | output | 1 | Protection-key violation |
| resp_err | output | 16 | Page-fault error-code word |

## Verification
The bench walks a lone access-disable bit through all sixteen domains. It probes the key after each one, so a key taken from the wrong entry bits, or a domain indexed with the wrong stride, faults on the wrong page. Write-disable is tried for reads, user writes and supervisor writes with write-protect off and on. A design that drops the write-protect term, or that applies write-disable to reads, gives the wrong flag there. Each gating input is closed in turn with full rights, so a missed gate reports a fault where none may occur. A rights write is issued in the same cycle as a request and again one cycle before a request, which catches a bypass or a late load.

// File: rtl/pkchk_pkg.sv
// Package: shared widths, field positions and request/control types for the
// protection-key checker. Assumes a 64-bit leaf entry with a 4-bit key field.
package pkchk_pkg;
    localparam int PTE_W     = 64;
    localparam int KEY_LSB   = 59;
    localparam int KEY_W     = 4;
    localparam int USER_BIT  = 2;
    localparam int ERR_W     = 16;
    localparam int ERR_PRES  = 0;
    localparam int ERR_WRITE = 1;
    localparam int ERR_USER  = 2;
    localparam int ERR_RSVD  = 3;
    localparam int ERR_FETCH = 4;
    localparam int ERR_PKEY  = 5;

    typedef struct packed {
        logic write;
        logic user;
        logic fetch;
        logic rsvd;
        logic present;
    } acc_req_t;

    typedef struct packed {
        logic key_en;
        logic long_mode;
        logic wp;
    } ctl_state_t;
endpackage

// File: rtl/pkchk_rights_reg.sv
// Rights register: holds two rights bits per key domain. A load is seen by the
// rest of the block from the cycle after the write strobe. Assumes sync reset.
module pkchk_rights_reg #(
    parameter int RIGHTS_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [RIGHTS_W-1:0] wdata,
    output logic [RIGHTS_W-1:0] q
);
    // Load new rights on a write strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end

    // R2
    rights_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(wdata)));
endmodule

// File: rtl/pkchk_key_lookup.sv
// Key lookup: splits the rights register into per-domain disable bits and
// selects the pair named by the page key. Assumes RIGHTS_W = 2 * 2**KEY_W.
module pkchk_key_lookup #(
    parameter int KEY_W    = 4,
    parameter int NUM_KEYS = 1 << KEY_W,
    parameter int RIGHTS_W = 2 * NUM_KEYS
) (
    input  logic [RIGHTS_W-1:0] rights,
    input  logic [KEY_W-1:0]    key,
    output logic                acc_dis,
    output logic                wr_dis,
    output logic                any_set
);
    logic [NUM_KEYS-1:0] ad_vec;
    logic [NUM_KEYS-1:0] wd_vec;

    // One access-disable and one write-disable bit per domain, interleaved.
    for (genvar g = 0; g < NUM_KEYS; g++) begin : g_dom
        assign ad_vec[g] = rights[2*g];
        assign wd_vec[g] = rights[2*g+1];
    end

    // Select the domain of the page and flag a non-empty register.
    always_comb begin
        acc_dis = ad_vec[key];
        wr_dis  = wd_vec[key];
        any_set = |rights;
    end
endmodule

// File: rtl/pkchk_decide.sv
// Decision logic: combines the access attributes, the control state and the
// selected rights bits into the protection-key violation. Purely combinational.
module pkchk_decide
    import pkchk_pkg::*;
(
    input  acc_req_t   req,
    input  ctl_state_t ctl,
    input  logic       user_page,
    input  logic       acc_dis,
    input  logic       wr_dis,
    input  logic       any_set,
    output logic       violation
);
    logic eligible;
    logic wr_block;

    // Gates that must all be open before rights are consulted.
    always_comb begin
        eligible = ctl.key_en && ctl.long_mode && req.present && !req.rsvd
                   && !req.fetch && user_page && any_set;
    end

    // Write-disable applies to data writes under write-protect or user mode.
    always_comb begin
        wr_block = wr_dis && req.write && (ctl.wp || req.user);
    end

    // Final verdict.
    always_comb begin
        violation = eligible && (acc_dis || wr_block);
    end
endmodule

// File: rtl/pkey_access_checker.sv
// Top: protection-key access checker. Extracts the page key and user bit from
// the leaf entry, looks up the rights of that key and registers the verdict and
// error-code word one clock after the request. Assumes a synchronous reset.
module pkey_access_checker
    import pkchk_pkg::*;
#(
    parameter int KEY_W    = pkchk_pkg::KEY_W,
    parameter int NUM_KEYS = 1 << KEY_W,
    parameter int RIGHTS_W = 2 * NUM_KEYS,
    parameter int ERR_BITS = pkchk_pkg::ERR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [63:0]         req_pte,
    input  logic                req_write,
    input  logic                req_user,
    input  logic                req_fetch,
    input  logic                req_rsvd,
    input  logic                req_present,
    input  logic                ctl_key_en,
    input  logic                ctl_long_mode,
    input  logic                ctl_wp,
    input  logic                rights_we,
    input  logic [RIGHTS_W-1:0] rights_wdata,
    output logic [RIGHTS_W-1:0] rights_rdata,
    output logic                resp_valid,
    output logic                resp_violation,
    output logic [ERR_BITS-1:0] resp_err
);
    acc_req_t            req;
    ctl_state_t          ctl;
    logic [KEY_W-1:0]    page_key;
    logic                user_page;
    logic [RIGHTS_W-1:0] rights_q;
    logic                acc_dis, wr_dis, any_set, viol_d;
    logic [ERR_BITS-1:0] err_d;

    // Pack the request and control inputs, and pull fields from the entry.
    always_comb begin
        req       = '{write: req_write, user: req_user, fetch: req_fetch,
                      rsvd: req_rsvd, present: req_present};
        ctl       = '{key_en: ctl_key_en, long_mode: ctl_long_mode, wp: ctl_wp};
        page_key  = req_pte[KEY_LSB +: KEY_W];
        user_page = req_pte[USER_BIT];
    end

    pkchk_rights_reg #(.RIGHTS_W(RIGHTS_W)) u_rights (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rights_we),
        .wdata (rights_wdata),
        .q     (rights_q)
    );

    pkchk_key_lookup #(.KEY_W(KEY_W), .NUM_KEYS(NUM_KEYS), .RIGHTS_W(RIGHTS_W)) u_lookup (
        .rights  (rights_q),
        .key     (page_key),
        .acc_dis (acc_dis),
        .wr_dis  (wr_dis),
        .any_set (any_set)
    );

    pkchk_decide u_decide (
        .req       (req),
        .ctl       (ctl),
        .user_page (user_page),
        .acc_dis   (acc_dis),
        .wr_dis    (wr_dis),
        .any_set   (any_set),
        .violation (viol_d)
    );

    // Compose the error-code word from the attributes and the verdict.
    always_comb begin
        err_d            = '0;
        err_d[ERR_PRES]  = req_present;
        err_d[ERR_WRITE] = req_write;
        err_d[ERR_USER]  = req_user;
        err_d[ERR_RSVD]  = req_rsvd;
        err_d[ERR_FETCH] = req_fetch;
        err_d[ERR_PKEY]  = viol_d;
    end

    // Register the result; outputs stay zero in cycles without a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid     <= 1'b0;
            resp_violation <= 1'b0;
            resp_err       <= '0;
        end else begin
            resp_valid     <= req_valid;
            resp_violation <= req_valid && viol_d;
            resp_err       <= req_valid ? err_d : '0;
        end
    end

    assign rights_rdata = rights_q;

    // R4
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !(ctl_key_en && ctl_long_mode) |=> !resp_violation);
    // R5
    absent_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (!req_present || req_rsvd) |=> !resp_violation);
    // R6
    fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_fetch |=> !resp_violation);
    // R7
    kernel_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_pte[USER_BIT] |=> !resp_violation);
    // R10
    empty_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (rights_q == '0) |=> !resp_violation);
    // R11
    err_key_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_err[ERR_PKEY] == resp_violation));
    // R12
    resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    // R12
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && !resp_violation && (resp_err == '0)));
endmodule

// File: tb/pkey_access_checker_bench.sv
module pkey_access_checker_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_user, req_fetch, req_rsvd, req_present;
    logic [63:0] req_pte;
    logic        ctl_key_en, ctl_long_mode, ctl_wp;
    logic        rights_we;
    logic [31:0] rights_wdata, rights_rdata;
    logic        resp_valid, resp_violation;
    logic [15:0] resp_err;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_rights = '0;

    typedef struct {
        logic        viol;
        logic [15:0] err;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    pkey_access_checker u_pkey_access_checker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pte(req_pte),
        .req_write(req_write), .req_user(req_user), .req_fetch(req_fetch),
        .req_rsvd(req_rsvd), .req_present(req_present), .ctl_key_en(ctl_key_en),
        .ctl_long_mode(ctl_long_mode), .ctl_wp(ctl_wp), .rights_we(rights_we),
        .rights_wdata(rights_wdata), .rights_rdata(rights_rdata),
        .resp_valid(resp_valid), .resp_violation(resp_violation), .resp_err(resp_err)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Leaf entry with a given key and user bit; bit 63 and low bits as noise.
    function automatic logic [63:0] mk_pte(input int key, input logic usr);
        logic [63:0] p;
        p = 64'h8000_0ABC_DEF0_1001;
        p = p | (64'(key) << 59) | (64'(usr) << 2);
        return p;
    endfunction

    // Reference rules from the requirements.
    function automatic logic ref_viol(input logic [31:0] r, input logic [63:0] p,
        input logic w, input logic u, input logic f, input logic rs, input logic pr,
        input logic ke, input logic lm, input logic wp);
        int k;
        logic ad, wd;
        k  = int'(p[62:59]);
        ad = r[k*2];
        wd = r[k*2+1];
        if (!(ke && lm) || !pr || rs || f || !p[2]) return 1'b0;
        return ad || (wd && w && (wp || u));
    endfunction

    task automatic send(input logic [63:0] p, input logic w, input logic u,
        input logic f, input logic rs, input logic pr, input logic ke,
        input logic lm, input logic wp, input string tag);
        exp_t e;
        @(negedge clk);
        rights_we = 1'b0;
        req_valid = 1'b1; req_pte = p; req_write = w; req_user = u;
        req_fetch = f; req_rsvd = rs; req_present = pr;
        ctl_key_en = ke; ctl_long_mode = lm; ctl_wp = wp;
        e.viol = ref_viol(model_rights, p, w, u, f, rs, pr, ke, lm, wp);
        e.err  = {10'b0, e.viol, f, rs, u, w, pr};
        e.tag  = tag;
        sb.push_back(e);
    endtask

    // Plain eligible read/write with a chosen key.
    task automatic acc(input int key, input logic w, input logic u,
                       input logic wp, input string tag);
        send(mk_pte(key, 1'b1), w, u, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, wp, tag);
    endtask

    // Drives a rights load; the strobe is dropped by the next send or idle.
    task automatic load_rights(input logic [31:0] v);
        @(negedge clk);
        req_valid = 1'b0;
        rights_we = 1'b1; rights_wdata = v;
        model_rights = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0; rights_we = 1'b0;
        end
    endtask

    // Monitor: pops the scoreboard for every result, checks idle cycles.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (resp_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R12 unexpected resp_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(resp_violation == e.viol, {e.tag, " violation"},
                          64'(resp_violation), 64'(e.viol));
                    check(resp_err == e.err, {"R11 ", e.tag, " err"},
                          64'(resp_err), 64'(e.err));
                end
            end else begin
                check(!resp_violation && resp_err == 16'h0, "R12 idle outputs",
                      {47'b0, resp_violation, resp_err}, 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b1; req_pte = mk_pte(3, 1'b1); req_write = 1'b1;
        req_user = 1'b1; req_fetch = 1'b0; req_rsvd = 1'b0; req_present = 1'b1;
        ctl_key_en = 1'b1; ctl_long_mode = 1'b1; ctl_wp = 1'b1;
        rights_we = 1'b1; rights_wdata = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        // R1: reset dominates a write strobe and a request
        check(rights_rdata == 32'h0, "R1 rights reset", 64'(rights_rdata), 0);
        check(!resp_valid && !resp_violation && resp_err == 16'h0, "R1 outputs reset",
              {46'b0, resp_valid, resp_violation, resp_err}, 0);
        req_valid = 1'b0; rights_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R10: empty rights never fault
        acc(5, 1'b1, 1'b1, 1'b1, "R10 zero rights write");
        acc(0, 1'b0, 1'b1, 1'b1, "R10 zero rights read");

        // R3 R8: walk a lone access-disable bit over every key
        for (int k = 0; k < 16; k++) begin
            load_rights(32'h1 << (2*k));
            acc(k, 1'b0, 1'b1, 1'b0, "R8 ad read own key");
            acc(k, 1'b1, 1'b0, 1'b0, "R8 ad write own key");
            acc((k + 1) % 16, 1'b1, 1'b1, 1'b1, "R3 ad other key");
        end
        idle(1);
        check(rights_rdata == 32'h4000_0000, "R2 readback",
              64'(rights_rdata), 64'h4000_0000);

        // R9: write-disable only
        load_rights(32'h1 << (2*6 + 1));
        acc(6, 1'b0, 1'b1, 1'b1, "R9 wd read");
        acc(6, 1'b1, 1'b1, 1'b0, "R9 wd user write no wp");
        acc(6, 1'b1, 1'b0, 1'b1, "R9 wd sup write wp");
        acc(6, 1'b1, 1'b0, 1'b0, "R9 wd sup write no wp");
        acc(7, 1'b1, 1'b1, 1'b1, "R3 wd other key");
        acc(3, 1'b1, 1'b1, 1'b1, "R3 wd key3 uses bit 7");

        // Gates closed with full rights
        load_rights(32'hFFFF_FFFF);
        send(mk_pte(9, 1'b1), 1, 1, 0, 0, 1, 0, 1, 1, "R4 key disabled");
        send(mk_pte(9, 1'b1), 1, 1, 0, 0, 1, 1, 0, 1, "R4 not long mode");
        send(mk_pte(9, 1'b1), 1, 1, 0, 0, 0, 1, 1, 1, "R5 not present");
        send(mk_pte(9, 1'b1), 1, 1, 0, 1, 1, 1, 1, 1, "R5 reserved bit");
        send(mk_pte(9, 1'b1), 0, 1, 1, 0, 1, 1, 1, 1, "R6 fetch");
        send(mk_pte(9, 1'b0), 1, 1, 0, 0, 1, 1, 1, 1, "R7 kernel page");
        send(mk_pte(9, 1'b1), 1, 1, 0, 0, 1, 1, 1, 1, "R8 all gates open");
        idle(2);

        // R2: write in the same cycle as a request uses the old rights
        @(negedge clk);
        begin
            exp_t e;
            req_valid = 1'b1; req_pte = mk_pte(2, 1'b1); req_write = 1'b0;
            req_user = 1'b1; req_fetch = 1'b0; req_rsvd = 1'b0; req_present = 1'b1;
            ctl_key_en = 1'b1; ctl_long_mode = 1'b1; ctl_wp = 1'b0;
            rights_we = 1'b1; rights_wdata = 32'h0;
            e.viol = 1'b1; e.err = 16'h0025; e.tag = "R2 old rights same cycle";
            sb.push_back(e);
            model_rights = 32'h0;
        end
        acc(2, 1'b0, 1'b1, 1'b0, "R2 new rights next cycle");
        check(rights_rdata == 32'h0, "R2 readback cleared", 64'(rights_rdata), 0);
        load_rights(32'h0000_0010);
        acc(2, 1'b0, 1'b1, 1'b0, "R2 load seen next cycle");
        idle(4);
        check(sb.size() == 0, "R12 all results returned", 64'(sb.size()), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule